// File: doc/BRIEF.md
# Vector catch detector

This block watches the instruction fetch stream for addresses that land on an exception vector slot and turns a hit into a one-cycle debug event. Each security world has its own vector base, given as an input, and eight word-sized slots above it. A catch-enable register holds one bit per slot per world. Any fetch counts, whether it comes from exception entry or from an ordinary prefetch, as long as the address is a slot of the world the fetch was made in and that slot's enable bit is set.

The hit is not reported at fetch time. It is recorded against the fetch tag and reported only when the pipeline commits an instruction carrying that tag. A flush throws away every pending record, so a prefetch that never commits never raises an event.

Top module: `vcatch_unit`

## Requirements
- R1: After reset the enable register reads zero, no fetch records are pending and `catch_evt` is low.
- R2: A cycle with `cfg_we` high loads `cfg_wdata` into the enable register, and `cfg_rdata` shows the new value from the following cycle. Bits 7:0 enable the secure slots 0..7 and bits 15:8 enable the non-secure slots 0..7.
- R3: A fetch whose address equals world base + 4*k (k = 0..7, k ≠ 5), with `fetch_ns` selecting the world (0 = secure with `sec_base`, 1 = non-secure with `ns_base`) and the matching enable bit set, followed later by a commit with the same tag, drives `catch_evt` high in the cycle after the commit.
- R4: An address that is a slot only of the other world's base causes no event.
- R5: An address that is not a multiple of 4 above the base, or that is 32 or more above it, causes no event.
- R6: The enable bit is taken at the fetch cycle; writing the register later neither adds nor removes the event for that fetch, and a write in the fetch cycle itself takes effect only for later fetches.
- R7: `catch_evt` rises only in the cycle after a commit, lasts that single cycle per commit, and a record is used up by its commit, so a second commit of the same tag gives no event.
- R8: `flush` discards every pending record and any fetch presented in the same cycle, and a commit in the flush cycle gives no event.
- R9: A commit and a fetch with the same tag in one cycle: the commit uses the earlier record and the new fetch replaces it.
- R10: Slot 5 (offset 0x14) never catches; enable bits 5 and 13 always read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Enable register write strobe |
| cfg_wdata | input | 16 | Enable register write value |
| cfg_rdata | output | 16 | Enable register contents |
| sec_base | input | 32 | Secure vector base address |
| ns_base | input | 32 | Non-secure vector base address |
| fetch_vld | input | 1 | A fetch is presented this cycle |
| fetch_addr | input | 32 | Fetch address |
| fetch_ns | input | 1 | World of the fetch, 1 = non-secure |
| fetch_id | input | 4 | Tag of the fetch |
| commit_vld | input | 1 | An instruction commits this cycle |
| commit_id | input | 4 | Tag of the committing instruction |
| flush | input | 1 | Discard all pending fetch records |
| catch_evt | output | 1 | One-cycle vector catch event |

## Verification
A wrong pending record stays hidden until its tag commits, so it shows only as a missing or extra `catch_evt` pulse one cycle after that commit, which may be many cycles after the faulty fetch. A corrupted enable register is visible on `cfg_rdata` in the very next cycle. The bench therefore keeps a tag-indexed model of pending records and compares both outputs every cycle, with random tags reused often so that stale or leaked records surface within a few dozen cycles.

// File: rtl/vcatch_pkg.sv
package vcatch_pkg;

    // World of a fetch
    typedef enum logic {
        WORLD_SEC = 1'b0,
        WORLD_NS  = 1'b1
    } world_e;

    localparam int VC_SLOTS  = 8;
    localparam int VC_HOLE   = 5;
    localparam int VC_WORLDS = 2;

endpackage

// File: rtl/vcatch_decode.sv
module vcatch_decode #(
    parameter int ADDR_W = 32,
    parameter int SLOTS  = 8,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic [SLOT_W-1:0] slot_o
);
    localparam int SPAN_W = SLOT_W + 2;

    logic [ADDR_W-1:0] offs;

    always_comb begin
        offs   = addr_i - base_i;
        hit_o  = (offs[1:0] == 2'b00) && (offs[ADDR_W-1:SPAN_W] == '0);
        slot_o = offs[SPAN_W-1:2];
    end
endmodule

// File: rtl/vcatch_hits.sv
module vcatch_hits #(
    parameter int ID_W = 4,
    localparam int DEPTH = 1 << ID_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear_all,
    input  logic            rd_clr,
    input  logic [ID_W-1:0] rd_idx,
    output logic            rd_val,
    input  logic            set_we,
    input  logic [ID_W-1:0] set_idx,
    input  logic            set_val
);
    logic [DEPTH-1:0] pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (clear_all) begin
            pend_d = '0;
        end else begin
            if (rd_clr) pend_d[rd_idx] = 1'b0;
            if (set_we) pend_d[set_idx] = set_val;
        end
        rd_val = pend_q[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end
endmodule

// File: rtl/vcatch_unit.sv
module vcatch_unit
    import vcatch_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ID_W   = 4,
    parameter int SLOTS  = VC_SLOTS,
    parameter int HOLE   = VC_HOLE,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int CFG_W  = VC_WORLDS * SLOTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic [ADDR_W-1:0] sec_base,
    input  logic [ADDR_W-1:0] ns_base,
    input  logic              fetch_vld,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_ns,
    input  logic [ID_W-1:0]   fetch_id,
    input  logic              commit_vld,
    input  logic [ID_W-1:0]   commit_id,
    input  logic              flush,
    output logic              catch_evt
);
    localparam logic [CFG_W-1:0] CFG_MASK =
        ~((CFG_W'(1) << HOLE) | (CFG_W'(1) << (SLOTS + HOLE)));

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic             evt;
    } st_t;

    st_t st_d, st_q;

    logic [VC_WORLDS-1:0] dec_hit;
    logic [SLOT_W-1:0]    dec_slot [VC_WORLDS];
    world_e               world;
    logic                 rec_hit;
    logic                 pend_rd;

    // One decoder per world, each against its own base
    for (genvar w = 0; w < VC_WORLDS; w++) begin : g_world
        vcatch_decode #(
            .ADDR_W(ADDR_W),
            .SLOTS (SLOTS)
        ) u_dec (
            .base_i(w == int'(WORLD_NS) ? ns_base : sec_base),
            .addr_i(fetch_addr),
            .hit_o (dec_hit[w]),
            .slot_o(dec_slot[w])
        );
    end

    always_comb begin
        world   = world_e'(fetch_ns);
        rec_hit = dec_hit[world] && st_q.cfg[{world, dec_slot[world]}];
    end

    vcatch_hits #(
        .ID_W(ID_W)
    ) u_hits (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_all(flush),
        .rd_clr   (commit_vld),
        .rd_idx   (commit_id),
        .rd_val   (pend_rd),
        .set_we   (fetch_vld),
        .set_idx  (fetch_id),
        .set_val  (rec_hit)
    );

    always_comb begin
        st_d     = st_q;
        st_d.evt = commit_vld && !flush && pend_rd;
        if (cfg_we) st_d.cfg = cfg_wdata & CFG_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_rdata = st_q.cfg;
    assign catch_evt = st_q.evt;
endmodule

// File: rtl/vcatch_chk.sv
module vcatch_chk #(
    parameter int SLOTS = 8,
    parameter int HOLE  = 5,
    localparam int CFG_W = 2 * SLOTS
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic [CFG_W-1:0] cfg_rdata,
    input logic             commit_vld,
    input logic             flush,
    input logic             catch_evt
);
    // R2
    cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_we)) |->
            (cfg_rdata[HOLE-1:0] == $past(cfg_wdata[HOLE-1:0])));

    // R10
    hole_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[HOLE] == 1'b0) && (cfg_rdata[SLOTS+HOLE] == 1'b0));

    // R7
    evt_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        catch_evt |-> ($past(rst_n) && $past(commit_vld)));

    // R8
    flush_kills_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(flush)) |-> !catch_evt);

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cfg_we)) |-> $stable(cfg_rdata));
endmodule

bind vcatch_unit vcatch_chk #(
    .SLOTS(SLOTS),
    .HOLE (HOLE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .commit_vld(commit_vld),
    .flush     (flush),
    .catch_evt (catch_evt)
);

// File: tb/sim_vcatch_unit.sv
module sim_vcatch_unit;
    localparam int ADDR_W = 32;
    localparam int ID_W   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [31:0] sec_base = 32'h0000_0000;
    logic [31:0] ns_base  = 32'hFFFF_0000;
    logic        fetch_vld = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        fetch_ns = 1'b0;
    logic [3:0]  fetch_id = '0;
    logic        commit_vld = 1'b0;
    logic [3:0]  commit_id = '0;
    logic        flush = 1'b0;
    logic        catch_evt;

    int checks = 0;
    int errors = 0;

    // bench model
    logic [15:0] m_cfg = '0;
    bit          m_pend [16];
    logic        m_evt = 1'b0;

    always #4 clk = ~clk;

    vcatch_unit #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .sec_base(sec_base), .ns_base(ns_base),
        .fetch_vld(fetch_vld), .fetch_addr(fetch_addr), .fetch_ns(fetch_ns),
        .fetch_id(fetch_id), .commit_vld(commit_vld), .commit_id(commit_id),
        .flush(flush), .catch_evt(catch_evt)
    );

    // slot number of an address above a base, -1 when not a usable slot
    function automatic int slot_of(logic [31:0] a, logic [31:0] b);
        logic [31:0] d = a - b;
        if (d % 4 != 0 || d >= 32) return -1;
        if (d / 4 == 5) return -1;
        return int'(d / 4);
    endfunction

    function automatic bit fetch_catches();
        int s;
        s = slot_of(fetch_addr, fetch_ns ? ns_base : sec_base);
        if (s < 0) return 1'b0;
        return m_cfg[(fetch_ns ? 8 : 0) + s];
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(string tag);
        bit nh;
        nh = fetch_catches();
        m_evt = commit_vld && !flush && m_pend[commit_id];
        if (flush) begin
            foreach (m_pend[i]) m_pend[i] = 1'b0;
        end else begin
            if (commit_vld) m_pend[commit_id] = 1'b0;
            if (fetch_vld)  m_pend[fetch_id] = nh;
        end
        if (cfg_we) m_cfg = cfg_wdata & 16'hDFDF;
        @(posedge clk);
        #1;
        check({tag, " evt"}, 16'(catch_evt), 16'(m_evt));
        check({tag, " cfg"}, cfg_rdata, m_cfg);
        @(negedge clk);
        cfg_we = 1'b0; fetch_vld = 1'b0; commit_vld = 1'b0; flush = 1'b0;
    endtask

    task automatic fetch(logic [31:0] a, logic ns, logic [3:0] id);
        fetch_vld = 1'b1; fetch_addr = a; fetch_ns = ns; fetch_id = id;
    endtask

    task automatic commit(logic [3:0] id);
        commit_vld = 1'b1; commit_id = id;
    endtask

    task automatic wr(logic [15:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: run did not end");
        finish_run();
    end

    initial begin
        int seed;
        seed = 7;
        void'($urandom(seed));
        foreach (m_pend[i]) m_pend[i] = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 evt", 16'(catch_evt), 16'h0);
        check("R1 cfg", cfg_rdata, 16'h0);
        rst_n = 1'b1;

        // R2 R10: write all ones, hole bits read zero
        wr(16'hFFFF); step("R2/R10 write");
        check("R10 hole", cfg_rdata, 16'hDFDF);

        // R3 secure slot 0, non-secure slot 2
        fetch(sec_base, 1'b0, 4'd3); step("R3 fetch sec");
        commit(4'd3); step("R3 commit sec");
        step("R7 single cycle");
        fetch(ns_base + 8, 1'b1, 4'd4); step("R3 fetch ns");
        commit(4'd4); step("R3 commit ns");
        // R7 second commit of a used tag
        commit(4'd4); step("R7 reuse");

        // R4 other world's base
        fetch(ns_base + 4, 1'b0, 4'd5); step("R4 fetch");
        commit(4'd5); step("R4 commit");

        // R5 unaligned and out of window
        fetch(sec_base + 2, 1'b0, 4'd6); step("R5 fetch unaligned");
        commit(4'd6); step("R5 commit unaligned");
        fetch(sec_base + 32, 1'b0, 4'd7); step("R5 fetch far");
        commit(4'd7); step("R5 commit far");

        // R10 slot 5
        fetch(sec_base + 32'h14, 1'b0, 4'd1); step("R10 fetch");
        commit(4'd1); step("R10 commit");

        // R6 enable taken at fetch
        fetch(sec_base + 4, 1'b0, 4'd8); step("R6 fetch");
        wr(16'h0000); step("R6 clear");
        commit(4'd8); step("R6 commit kept");
        fetch(sec_base + 4, 1'b0, 4'd9); wr(16'hFFFF); step("R6 fetch same write");
        commit(4'd9); step("R6 commit none");

        // R8 flush
        fetch(sec_base, 1'b0, 4'd10); step("R8 fetch");
        flush = 1'b1; step("R8 flush");
        commit(4'd10); step("R8 commit");
        fetch(sec_base, 1'b0, 4'd11); step("R8 fetch b");
        fetch(sec_base, 1'b0, 4'd12); commit(4'd11); flush = 1'b1; step("R8 flush with commit");
        commit(4'd12); step("R8 flushed fetch");

        // R9 commit and fetch same tag
        fetch(sec_base + 12, 1'b0, 4'd13); step("R9 fetch");
        fetch(sec_base + 2, 1'b0, 4'd13); commit(4'd13); step("R9 overlap");
        commit(4'd13); step("R9 replaced");
        fetch(sec_base + 2, 1'b0, 4'd14); step("R9 miss fetch");
        fetch(ns_base + 28, 1'b1, 4'd14); commit(4'd14); step("R9 overlap b");
        commit(4'd14); step("R9 replaced b");

        // random phase
        for (int n = 0; n < 3000; n++) begin
            int sel;
            logic [31:0] b;
            if ($urandom % 10 == 0) wr(16'($urandom));
            if ($urandom % 10 < 6) begin
                fetch_ns = 1'($urandom);
                sel = $urandom % 10;
                b = (sel < 7) ? (fetch_ns ? ns_base : sec_base)
                              : (fetch_ns ? sec_base : ns_base);
                fetch(b + (($urandom % 10 < 8) ? 4 * ($urandom % 10) : $urandom % 40),
                      fetch_ns, 4'($urandom));
            end
            if ($urandom % 2 == 0) commit(4'($urandom));
            if ($urandom % 20 == 0) flush = 1'b1;
            step("R3/R4/R5/R6/R7/R8/R9 random");
        end
        finish_run();
    end
endmodule